// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a logical address skips paged translation. It keeps four window registers. Two of them serve data accesses and two serve instruction fetches. Each window compares the top address byte against an 8-bit base, and an 8-bit mask turns chosen bits into don't-cares. A window also checks the privilege level of the access and supplies two memory attributes: write protection and a cache mode.

For each access the address, a code/data flag, a supervisor flag and a store flag are presented. The lookup is purely combinational against the register contents. The code/data flag picks the pair of windows that takes part. When both windows of that pair match, the lower-numbered window supplies the attributes. A store that lands in a write-protected window raises a protection fault instead of a hit. The registers are loaded through a simple write port. They are cleared by reset, so no window is active until software programs one.

Top module: `ttw_matcher`

## Requirements
- R1: After reset all four registers read as zero, so every lookup misses: `hit_o`, `fault_o`, `wp_o` are 0 and `cmode_o` is 0.
- R2: A window matches when `((addr_i[31:24] ^ reg[31:24]) & ~reg[23:16]) == 0`. A mask bit of 1 makes that address bit a don't-care.
- R3: Register bit 15 enables the window. A window with bit 15 clear never matches.
- R4: Register bits 14:13 form the privilege field. 00 matches only accesses with `super_i`=0, 01 matches only accesses with `super_i`=1, and 1x matches both.
- R5: `wr_idx_i` 0 and 1 address the data windows and 2 and 3 address the instruction windows. `code_i`=1 consults only windows 2 and 3, and `code_i`=0 consults only windows 0 and 1.
- R6: For the winning window, `wp_o` is register bit 2 and `cmode_o` is bits 6:5. The cache mode encodings are 00 write-through, 01 copyback, 10 serialized and 11 non-cached.
- R7: When both windows of the selected pair match, the lower index of the pair (0 or 2) supplies the attributes.
- R8: A match with the winning window's bit 2 set and `store_i`=1 drives `fault_o`=1 and `hit_o`=0. A load to the same window gives `hit_o`=1 with `wp_o`=1.
- R9: With no matching window, `hit_o`, `fault_o`, `wp_o` and `cmode_o` are all 0. `hit_o` and `fault_o` are never 1 together.
- R10: A write with `wr_en_i`=1 takes effect at the next rising clock edge. It changes only the register selected by `wr_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 2 | Register index: 0,1 data; 2,3 instruction |
| wr_data_i | input | 32 | Register write value |
| addr_i | input | 32 | Logical access address |
| code_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| super_i | input | 1 | 1 for a supervisor access |
| store_i | input | 1 | 1 for a write access |
| hit_o | output | 1 | Access bypasses paged translation |
| fault_o | output | 1 | Store into a write-protected window |
| wp_o | output | 1 | Write-protect attribute of the winning window |
| cmode_o | output | 2 | Cache mode of the winning window |

## Verification
On every cycle the assertions check four things. A disabled window never matches. A user-only window never matches a supervisor access. Hit and fault never appear together, and a fault always comes from a store. A miss yields zero attributes. They also check that a write lands in the addressed register one edge later. Only the bench scenarios can show the rest: the mask arithmetic on concrete addresses, the choice of pair from the code/data flag, the lower-index priority when two windows overlap, and the isolation of one register from writes to another.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int TTW_AW     = 32;
  localparam int TTW_TAG_W  = 8;
  localparam int TTW_REG_W  = 32;
  localparam int BASE_LSB   = 24;
  localparam int MASK_LSB   = 16;
  localparam int EN_BIT     = 15;
  localparam int PRIV_LSB   = 13;
  localparam int CM_LSB     = 5;
  localparam int WP_BIT     = 2;

  typedef enum logic [1:0] {
    CM_WTHRU   = 2'b00,
    CM_COPYBK  = 2'b01,
    CM_SERIAL  = 2'b10,
    CM_NOCACHE = 2'b11
  } cmode_e;

  typedef struct packed {
    logic   wp;
    cmode_e cmode;
  } win_attr_t;

  typedef struct packed {
    logic [TTW_TAG_W-1:0] base;
    logic [TTW_TAG_W-1:0] mask;
    logic                 en;
    logic [1:0]           priv;
    win_attr_t            attr;
  } win_cfg_t;
endpackage

// File: rtl/ttw_reg_bank.sv
module ttw_reg_bank
  import ttw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [TTW_REG_W-1:0] wr_data_i,
  output logic [TTW_REG_W-1:0] regs_o [NUM_WIN]
);
  logic [TTW_REG_W-1:0] regs_q [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    regs_q[g] <= wr_data_i;
    end
    assign regs_o[g] = regs_q[g];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_idx_i)] == $past(wr_data_i)); // R10
endmodule

// File: rtl/ttw_window_match.sv
module ttw_window_match
  import ttw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TTW_REG_W-1:0] reg_i,
  input  logic [TTW_TAG_W-1:0] tag_i,
  input  logic                 super_i,
  output logic                 match_o,
  output win_attr_t            attr_o
);
  win_cfg_t cfg;
  logic     addr_ok, priv_ok;
  logic     unused_bits;

  assign cfg.base       = reg_i[BASE_LSB +: TTW_TAG_W];
  assign cfg.mask       = reg_i[MASK_LSB +: TTW_TAG_W];
  assign cfg.en         = reg_i[EN_BIT];
  assign cfg.priv       = reg_i[PRIV_LSB +: 2];
  assign cfg.attr.wp    = reg_i[WP_BIT];
  assign cfg.attr.cmode = cmode_e'(reg_i[CM_LSB +: 2]);
  assign unused_bits    = ^{reg_i[12:7], reg_i[4:3], reg_i[1:0]};

  // masked bits compare as equal
  assign addr_ok = ((tag_i ^ cfg.base) & ~cfg.mask) == '0;
  // priv[1] set: both levels; else priv[0] must equal the level
  assign priv_ok = cfg.priv[1] | (cfg.priv[0] == super_i);
  assign match_o = cfg.en & addr_ok & priv_ok;
  assign attr_o  = cfg.attr;

  AST_DISABLED_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_i[EN_BIT] |-> !match_o); // R3
  AST_USER_ONLY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_i[PRIV_LSB +: 2] == 2'b00 && super_i) |-> !match_o); // R4
endmodule

// File: rtl/ttw_pair_select.sv
module ttw_pair_select
  import ttw_pkg::*;
#(
  parameter int WIN_PER_KIND = 2,
  localparam int NUM_WIN     = 2 * WIN_PER_KIND
) (
  input  logic [NUM_WIN-1:0] match_i,
  input  win_attr_t          attr_i [NUM_WIN],
  input  logic               code_i,
  output logic               any_o,
  output win_attr_t          attr_o
);
  logic [WIN_PER_KIND-1:0] grp_match;
  win_attr_t               grp_attr [WIN_PER_KIND];

  for (genvar g = 0; g < WIN_PER_KIND; g++) begin : g_grp
    assign grp_match[g] = code_i ? match_i[WIN_PER_KIND + g] : match_i[g];
    assign grp_attr[g]  = code_i ? attr_i[WIN_PER_KIND + g]  : attr_i[g];
  end

  // lowest index in the pair wins
  always_comb begin
    any_o  = 1'b0;
    attr_o = '0;
    for (int i = WIN_PER_KIND - 1; i >= 0; i--) begin
      if (grp_match[i]) begin
        any_o  = 1'b1;
        attr_o = grp_attr[i];
      end
    end
  end
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
  import ttw_pkg::*;
#(
  parameter int WIN_PER_KIND = 2,
  localparam int NUM_WIN     = 2 * WIN_PER_KIND,
  localparam int IDX_W       = $clog2(NUM_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic [31:0]      addr_i,
  input  logic             code_i,
  input  logic             super_i,
  input  logic             store_i,
  output logic             hit_o,
  output logic             fault_o,
  output logic             wp_o,
  output logic [1:0]       cmode_o
);
  logic [TTW_REG_W-1:0] regs [NUM_WIN];
  logic [NUM_WIN-1:0]   match;
  win_attr_t            attr [NUM_WIN];
  logic                 any;
  win_attr_t            win_attr;
  logic [TTW_TAG_W-1:0] tag;

  assign tag = addr_i[TTW_AW-1 -: TTW_TAG_W];

  ttw_reg_bank #(.NUM_WIN(NUM_WIN)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    ttw_window_match u_match (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .reg_i   (regs[g]),
      .tag_i   (tag),
      .super_i (super_i),
      .match_o (match[g]),
      .attr_o  (attr[g])
    );
  end

  ttw_pair_select #(.WIN_PER_KIND(WIN_PER_KIND)) u_sel (
    .match_i (match),
    .attr_i  (attr),
    .code_i  (code_i),
    .any_o   (any),
    .attr_o  (win_attr)
  );

  assign fault_o = any & store_i & win_attr.wp;
  assign hit_o   = any & ~(store_i & win_attr.wp);
  assign wp_o    = win_attr.wp;
  assign cmode_o = win_attr.cmode;

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o)); // R9
  AST_MISS_ATTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_o && !fault_o) |-> (!wp_o && cmode_o == 2'b00)); // R9
  AST_FAULT_NEEDS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (store_i && wp_o)); // R8
endmodule

// File: tb/ttw_matcher_bench.sv
module ttw_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] addr = '0;
  logic        code = 1'b0, sup = 1'b0, store = 1'b0;
  logic        hit, fault, wp;
  logic [1:0]  cmode;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ttw_matcher u_ttw_matcher (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .addr_i(addr), .code_i(code), .super_i(sup),
    .store_i(store), .hit_o(hit), .fault_o(fault), .wp_o(wp), .cmode_o(cmode)
  );

  typedef struct packed {
    logic [31:0] a;
    logic        c, s, st;
    logic        h, f, w;
    logic [1:0]  cm;
  } vec_t;

  // windows: 0 data 0x12/00 both-priv copyback; 1 data 0x40/0F super wp noncached;
  //          2 code 0x80/7F user serialized;   3 code any-byte both-priv wp writethru
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 R6
    '{32'h4A00_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3}, // R2 R4 R6
    '{32'h4A00_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 R9
    '{32'h4A00_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3}, // R8
    '{32'h5000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R2 R9
    '{32'h9000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2}, // R5 R7
    '{32'h9000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0}, // R4 R5
    '{32'h1200_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0}, // R5
    '{32'h1200_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1}, // R8
    '{32'h1234_5678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0}  // R5 R8
  };

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {hit,fault,wp,cmode} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [1:0] idx, logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] a, logic c, logic s, logic st);
    addr = a; code = c; sup = s; store = st;
    #1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: all windows clear after reset
    for (int k = 0; k < 8; k++) begin
      look(32'h0000_0000 | (32'(k) << 24), k[0], k[1], k[2]);
      check("R1", {hit, fault, wp, cmode}, 5'b0);
    end

    write_reg(2'd0, 32'h1200_C020);
    write_reg(2'd1, 32'h400F_A064);
    write_reg(2'd2, 32'h807F_8040);
    write_reg(2'd3, 32'h12FF_C004);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      look(VECS[i].a, VECS[i].c, VECS[i].s, VECS[i].st);
      check($sformatf("R2/R4-R9 vec%0d", i), {hit, fault, wp, cmode},
            {VECS[i].h, VECS[i].f, VECS[i].w, VECS[i].cm});
    end

    // R3: clear enable of window 0
    write_reg(2'd0, 32'h1200_4020);
    @(negedge clk);
    look(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    check("R3", {hit, fault, wp, cmode}, 5'b0);

    // R10: write not visible before the edge, visible after
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd0; wr_data = 32'h1200_C020;
    look(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    check("R10 before edge", {hit, fault, wp, cmode}, 5'b0);
    @(negedge clk);
    wr_en = 1'b0;
    look(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    check("R10 after edge", {hit, fault, wp, cmode}, 5'b10001);
    // R10: window 1 unchanged by writes to window 0
    look(32'h4300_0000, 1'b0, 1'b1, 1'b0);
    check("R10 other reg", {hit, fault, wp, cmode}, 5'b10111);

    // R7: both data windows match 0x12; window 0 wins
    write_reg(2'd1, 32'h1200_C064);
    look(32'h12AB_0000, 1'b0, 1'b1, 1'b0);
    check("R7 low wins", {hit, fault, wp, cmode}, 5'b10001);
    look(32'h12AB_0000, 1'b0, 1'b1, 1'b1);
    check("R7 store low wins", {hit, fault, wp, cmode}, 5'b10001);
    write_reg(2'd0, 32'h0000_0000);
    look(32'h12AB_0000, 1'b0, 1'b1, 1'b0);
    check("R7 high alone", {hit, fault, wp, cmode}, 5'b10111);
    look(32'h12AB_0000, 1'b0, 1'b1, 1'b1);
    check("R8 store fault", {hit, fault, wp, cmode}, 5'b01111);

    // R2: mask bit don't-care vs exact bit
    write_reg(2'd2, 32'hA001_C020);
    look(32'hA100_0000, 1'b1, 1'b0, 1'b0);
    check("R2 masked bit", {hit, fault, wp, cmode}, 5'b10001);
    look(32'hA200_0000, 1'b1, 1'b1, 1'b0);
    check("R2 exact bit", {hit, fault, wp, cmode}, 5'b10100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule